// File: doc/BRIEF.md
# AM Envelope Detector

This block recovers the baseband message from a sampled amplitude-modulated signal that still carries its full carrier. Every accepted input sample is rectified to its magnitude and pushed into a 31-tap lowpass filter. The filter keeps the message band (0.2 kHz to 3.8 kHz at a 48 kHz sample rate) and removes the rectified carrier, which for a 12 kHz carrier sits at DC and at half the sample rate. An optional stage removes the DC level that rectification leaves, using a leaky running mean.

The filter is time-multiplexed. A three-state controller accepts a sample in `S_IDLE`, walks the folded coefficient pairs in `S_MAC` (16 steps), and rounds the accumulator in `S_ROUND`. Transitions: `S_IDLE -> S_MAC` on an accepted strobe, `S_MAC -> S_MAC` while pairs remain, `S_MAC -> S_ROUND` after the centre tap, `S_ROUND -> S_IDLE` always. The input strobe runs at the 48 kHz sample rate, far below the clock, so the 18-cycle service time always fits between samples. A suppressed-carrier signal fed to the same block comes out distorted, because the rectifier folds the negative half of the message up onto the positive half.

Top module: `envelope_detector`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, accumulator, controller, DC estimate, `out_valid` and `out_sample` (to 0). A sample whose computation is cut short by reset produces no output.
- R2: The rectifier forms the magnitude of the Q1.15 input. The code -32768 maps to +32767.
- R3: The filter has 31 taps. The newest magnitude sits in tap 0. Tap j and tap 30-j share coefficient c(j), in units of 1/256. For j = 0..15, c(j) is 0, -1, -1, 0, 1, 3, 3, 0, -5, -9, -9, 0, 18, 39, 57, 64, and tap 15 is the centre. The gain at DC is exactly 1.
- R4: The products are added for j = 0 up to 15 in that order. For j < 15 the product is c(j)*(tap j + tap 30-j), and for j = 15 it is c(15)*tap 15. The sum is kept in a 24-bit signed accumulator that saturates to [-8388608, 8388607] after every addition.
- R5: The filter result is (acc + 128) shifted right arithmetically by 8, then saturated to [-32768, 32767].
- R6: `out_valid` is a one-cycle pulse, raised by the 18th rising edge after the edge that accepted `in_valid`. There is one output for each accepted sample.
- R7: An `in_valid` on any of the 17 edges after an accepted sample is ignored and leaves all later outputs unchanged.
- R8: With DC_REMOVE=1 and filter result y, the output is sat16(y - (m >>> 8)). The estimate m then becomes m + y - (m >>> 8). m is a wide signed value that starts at 0.
- R9: With DC_REMOVE=0, `out_sample` equals the filter result.
- R10: The input 0.5*(1+0.5 sin(2π·1.5k·n/48k))·sin(2π·n/4+π/4) yields, after settling, 0.5·0.7071·(1+0.5 sin(2π·1.5k·(n-15)/48k)) of full scale. The error is within 1 % of full scale, and the output correlates with the delayed message above 0.95.
- R11: The suppressed-carrier input 0.25·sin(2π·1.5k·n/48k)·sin(2π·n/4+π/4) yields an output whose correlation with the delayed message is below 0.2 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed Q1.15 modulated sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Signed demodulated sample |

## Verification
The bench builds two copies with the default widths (16-bit data, 8-bit coefficients, 24-bit accumulator): one with DC_REMOVE=0 and one with DC_REMOVE=1. Both receive the same stimulus, so the plain filter output and the DC-removed output are compared sample by sample with one shared reference model. A directed burst loads only the positive-coefficient taps with full-scale magnitudes. This drives the accumulator past 2^23, so both the accumulator clamp and the output clamp are exercised. Random samples (including -32768) cover the rectifier and the accumulation order. Tone tests show the full-carrier message being recovered and the suppressed-carrier case failing.

// File: rtl/envdet_pkg.sv
package envdet_pkg;

    localparam int TAPS      = 31;
    localparam int HALF_TAPS = TAPS / 2;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MAC,
        S_ROUND
    } mac_state_t;

    // Folded coefficient for the pair (j, TAPS-1-j); j == HALF_TAPS is the centre.
    function automatic int coef_at(input int j);
        int c;
        case (j)
            0:  c = 0;
            1:  c = -1;
            2:  c = -1;
            3:  c = 0;
            4:  c = 1;
            5:  c = 3;
            6:  c = 3;
            7:  c = 0;
            8:  c = -5;
            9:  c = -9;
            10: c = -9;
            11: c = 0;
            12: c = 18;
            13: c = 39;
            14: c = 57;
            15: c = 64;
            default: c = 0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/envdet_rect.sv
module envdet_rect #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] x,
    output logic        [DATA_W-1:0] mag
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (x == MOST_NEG) begin
            mag = MOST_POS;
        end else if (x[DATA_W-1]) begin
            mag = DATA_W'(-x);
        end else begin
            mag = x;
        end
    end
endmodule

// File: rtl/envdet_fir.sv
module envdet_fir #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 8,
    parameter int ACC_W     = 24,
    parameter int COEF_FRAC = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic        [DATA_W-1:0] in_mag,
    output logic                     y_valid,
    output logic signed [DATA_W-1:0] y
);
    import envdet_pkg::*;

    localparam int IDX_W      = $clog2(TAPS);
    localparam int PROD_W     = DATA_W + COEF_W + 2;
    localparam int SUM_W      = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
    localparam int ROUND_HALF = 1 << (COEF_FRAC - 1);
    localparam int TOP_LO     = COEF_FRAC + DATA_W - 1;
    localparam logic [ACC_W-1:0]  ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0]  ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    mac_state_t               state, state_nx;
    logic [DATA_W-1:0]        taps [TAPS];
    logic [IDX_W-1:0]         idx;
    logic [IDX_W-1:0]         mirror;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_next;
    logic [DATA_W:0]          pair_sum;
    logic signed [COEF_W-1:0] coef_now;
    logic signed [PROD_W-1:0] prod;
    logic [SUM_W-1:0]         sum_wide;
    logic [ACC_W:0]           rnd;
    logic [DATA_W-1:0]        y_round;
    logic                     unused_rnd_low;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nx = S_MAC;
            S_MAC:   if (idx == IDX_W'(HALF_TAPS)) state_nx = S_ROUND;
            S_ROUND: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Folded tap pair and its coefficient
    assign mirror = IDX_W'(TAPS - 1) - idx;

    always_comb begin
        pair_sum = {1'b0, taps[idx]} + {1'b0, taps[mirror]};
        if (idx == IDX_W'(HALF_TAPS)) begin
            pair_sum = {1'b0, taps[HALF_TAPS]};
        end
        coef_now = COEF_W'(coef_at(int'(idx)));
        prod     = PROD_W'($signed({1'b0, pair_sum})) * PROD_W'(coef_now);
        sum_wide = SUM_W'(acc) + SUM_W'(prod);
    end

    // Saturating accumulate
    always_comb begin
        if (!sum_wide[SUM_W-1] && (|sum_wide[SUM_W-2:ACC_W-1])) begin
            acc_next = ACC_MAX;
        end else if (sum_wide[SUM_W-1] && !(&sum_wide[SUM_W-2:ACC_W-1])) begin
            acc_next = ACC_MIN;
        end else begin
            acc_next = sum_wide[ACC_W-1:0];
        end
    end

    // Round half up, then saturate to the output width
    always_comb begin
        rnd = (ACC_W+1)'(acc) + (ACC_W+1)'(ROUND_HALF);
        if (!rnd[ACC_W] && (|rnd[ACC_W-1:TOP_LO])) begin
            y_round = OUT_MAX;
        end else if (rnd[ACC_W] && !(&rnd[ACC_W-1:TOP_LO])) begin
            y_round = OUT_MIN;
        end else begin
            y_round = rnd[COEF_FRAC +: DATA_W];
        end
    end
    assign unused_rnd_low = ^rnd[COEF_FRAC-1:0];

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) taps[i] <= '0;
            idx     <= '0;
            acc     <= '0;
            y_valid <= 1'b0;
            y       <= '0;
        end else begin
            y_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        for (int i = TAPS - 1; i > 0; i--) taps[i] <= taps[i-1];
                        taps[0] <= in_mag;
                        idx     <= '0;
                        acc     <= '0;
                    end
                end
                S_MAC: begin
                    acc <= acc_next;
                    idx <= idx + IDX_W'(1);
                end
                S_ROUND: begin
                    y       <= y_round;
                    y_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Assertions
    p_tap_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && in_valid) |=> !taps[0][DATA_W-1]);

    p_acc_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && in_valid) |=> (acc == '0));

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> ($stable(taps[0]) && $stable(taps[TAPS-1])));

    p_round_only_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(y_valid) |-> ($past(state) == S_ROUND));
endmodule

// File: rtl/envdet_dcblk.sv
module envdet_dcblk #(
    parameter int DATA_W    = 16,
    parameter bit DC_REMOVE = 1'b0,
    parameter int DC_SHIFT  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_y,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_y
);
    localparam int D_W = DATA_W + 2;
    localparam int M_W = DATA_W + DC_SHIFT + 2;
    localparam logic signed [D_W-1:0] LIM_MAX = D_W'((1 <<< (DATA_W-1)) - 1);
    localparam logic signed [D_W-1:0] LIM_MIN = -D_W'(1 <<< (DATA_W-1));

    generate
        if (DC_REMOVE) begin : g_dc_remove
            logic signed [M_W-1:0] mean_q;
            logic signed [M_W-1:0] mean_sh;
            logic signed [D_W-1:0] mean_est;
            logic signed [D_W-1:0] diff;
            logic                  unused_mean_hi;

            always_comb begin
                mean_sh  = mean_q >>> DC_SHIFT;
                mean_est = $signed(mean_sh[D_W-1:0]);
                diff     = D_W'(in_y) - mean_est;
            end
            assign unused_mean_hi = ^mean_sh[M_W-1:D_W];

            always_ff @(posedge clk) begin
                if (rst) begin
                    mean_q    <= '0;
                    out_valid <= 1'b0;
                    out_y     <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        mean_q <= mean_q + M_W'(in_y) - M_W'(mean_est);
                        if (diff > LIM_MAX) begin
                            out_y <= LIM_MAX[DATA_W-1:0];
                        end else if (diff < LIM_MIN) begin
                            out_y <= LIM_MIN[DATA_W-1:0];
                        end else begin
                            out_y <= diff[DATA_W-1:0];
                        end
                    end
                end
            end

            p_mean_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(mean_q));
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_y     <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) out_y <= in_y;
                end
            end

            p_pass_r9: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (out_y == $past(in_y)));
        end
    endgenerate
endmodule

// File: rtl/envelope_detector.sv
module envelope_detector #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 8,
    parameter int ACC_W     = 24,
    parameter int COEF_FRAC = 8,
    parameter bit DC_REMOVE = 1'b0,
    parameter int DC_SHIFT  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    logic [DATA_W-1:0]        mag;
    logic                     fir_valid;
    logic signed [DATA_W-1:0] fir_y;

    envdet_rect #(.DATA_W(DATA_W)) u_rect (
        .x   (in_sample),
        .mag (mag)
    );

    envdet_fir #(
        .DATA_W    (DATA_W),
        .COEF_W    (COEF_W),
        .ACC_W     (ACC_W),
        .COEF_FRAC (COEF_FRAC)
    ) u_fir (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_mag   (mag),
        .y_valid  (fir_valid),
        .y        (fir_y)
    );

    envdet_dcblk #(
        .DATA_W    (DATA_W),
        .DC_REMOVE (DC_REMOVE),
        .DC_SHIFT  (DC_SHIFT)
    ) u_dc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (fir_valid),
        .in_y      (fir_y),
        .out_valid (out_valid),
        .out_y     (out_sample)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    p_out_follows_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(fir_valid));
endmodule

// File: tb/test_envelope_detector.sv
`timescale 1ns/1ps
module test_envelope_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid, out_valid_dc;
    logic signed [15:0] out_sample, out_sample_dc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int dl [31];
    longint dcm;

    real am_out [300];
    real sc_out [300];

    always #2.5 clk = ~clk;

    envelope_detector #(.DC_REMOVE(1'b0)) i_envelope_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    envelope_detector #(.DC_REMOVE(1'b1)) i_envelope_detector_dc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid_dc), .out_sample(out_sample_dc)
    );

    function automatic int coef_of(input int j);
        int t [16] = '{0, -1, -1, 0, 1, 3, 3, 0, -5, -9, -9, 0, 18, 39, 57, 64};
        return t[j];
    endfunction

    function automatic longint clamp(input longint v, input longint lo, input longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int magnitude(input int x);
        if (x == -32768) return 32767;
        return (x < 0) ? -x : x;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 31; i++) dl[i] = 0;
        dcm = 0;
    endtask

    task automatic model_push(input int x, output int yf, output int yd);
        longint acc;
        longint p;
        for (int i = 30; i > 0; i--) dl[i] = dl[i-1];
        dl[0] = magnitude(x);
        acc = 0;
        for (int j = 0; j < 16; j++) begin
            p = (j == 15) ? dl[15] : dl[j] + dl[30-j];
            acc = clamp(acc + coef_of(j) * p, -8388608, 8388607);
        end
        yf = int'(clamp((acc + 128) >>> 8, -32768, 32767));
        yd = int'(clamp(longint'(yf) - (dcm >>> 8), -32768, 32767));
        dcm = dcm + yf - (dcm >>> 8);
    endtask

    // Drive one sample; optionally pulse in_valid while busy (must be ignored).
    task automatic send(input int x, input bit glitch, output int got);
        int ef, ed;
        bit early;
        model_push(x, ef, ed);
        early = 1'b0;
        in_valid = 1'b1;
        in_sample = 16'(x);
        for (int k = 1; k <= 19; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (glitch && (k == 2 || k == 17)) begin
                in_valid = 1'b1;
                in_sample = 16'sh8000;
            end
            if (k < 19 && (out_valid || out_valid_dc)) early = 1'b1;
        end
        check("R6 latency/pulse", {early, out_valid, out_valid_dc}, 3'b011);
        check(glitch ? "R7 busy strobe ignored" : "R3/R9 filter output", out_sample, ef);
        check("R8 dc removed output", out_sample_dc, ed);
        got = out_sample;
    endtask

    function automatic int to_q15(input real v);
        real s;
        s = v * 32768.0;
        s = (s >= 0.0) ? s + 0.5 : s - 0.5;
        return int'(clamp(longint'($rtoi(s)), -32768, 32767));
    endfunction

    function automatic real corr_msg(input bit use_sc);
        real mo, so, sm, num, d1, d2, o;
        mo = 0.0;
        for (int n = 40; n < 296; n++) mo += use_sc ? sc_out[n] : am_out[n];
        mo = mo / 256.0;
        num = 0.0; d1 = 0.0; d2 = 0.0;
        for (int n = 40; n < 296; n++) begin
            o  = (use_sc ? sc_out[n] : am_out[n]) - mo;
            sm = $sin(2.0 * 3.14159265358979 * real'(n - 15) / 32.0);
            num += o * sm; d1 += o * o; d2 += sm * sm;
        end
        so = $sqrt(d1 * d2);
        return (so > 0.0) ? num / so : 0.0;
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int got, x, maxerr, exp_env;
        int seed;
        real c_am, c_sc, pi2;
        bit seen;
        pi2 = 2.0 * 3.14159265358979;
        seed = 1234;
        void'($urandom(seed));
        model_reset();

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset out_sample", out_sample, 0);

        // R2: most negative code and simple impulses
        send(-32768, 1'b0, got);
        send(12345, 1'b0, got);
        send(-12345, 1'b0, got);

        // R3/R4/R5/R2: random stimulus with directed extremes
        for (int i = 0; i < 150; i++) begin
            case ($urandom % 8)
                0: x = -32768;
                1: x = 32767;
                default: x = int'($signed(16'($urandom)));
            endcase
            send(x, (i % 10) == 3, got);
        end

        // R4/R5: only positive-coefficient taps at full scale -> accumulator clamps
        for (int i = 0; i < 31; i++) begin
            int jj;
            jj = (i <= 15) ? i : 30 - i;
            send((coef_of(jj) > 0) ? -32768 : 0, 1'b0, got);
        end
        check("R4/R5 saturated output", got, 32767);

        // R1: reset during a computation aborts it and clears history
        in_valid = 1'b1; in_sample = 16'sd20000;
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        seen = 1'b0;
        for (int k = 0; k < 22; k++) begin
            @(negedge clk);
            if (out_valid || out_valid_dc) seen = 1'b1;
        end
        check("R1 aborted sample no output", seen, 0);
        send(30000, 1'b0, got);
        check("R1 cleared history", got, 0);
        for (int i = 0; i < 16; i++) send(30000, 1'b0, got);

        // R10: full-carrier AM
        model_reset();
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        for (int n = 0; n < 300; n++) begin
            real v;
            v = 0.5 * (1.0 + 0.5 * $sin(pi2 * real'(n) / 32.0)) * $sin(pi2 * real'(n) / 4.0 + pi2 / 8.0);
            send(to_q15(v), 1'b0, got);
            am_out[n] = real'(got);
        end
        maxerr = 0;
        for (int n = 40; n < 300; n++) begin
            exp_env = $rtoi(32768.0 * 0.5 * 0.70711 * (1.0 + 0.5 * $sin(pi2 * real'(n - 15) / 32.0)));
            if ($rtoi(am_out[n]) - exp_env > maxerr) maxerr = $rtoi(am_out[n]) - exp_env;
            if (exp_env - $rtoi(am_out[n]) > maxerr) maxerr = exp_env - $rtoi(am_out[n]);
        end
        check("R10 envelope error within 1pct", maxerr <= 330, 1);
        c_am = corr_msg(1'b0);
        check("R10 message correlation high", c_am > 0.95, 1);

        // R11: suppressed carrier gives a distorted output
        for (int n = 0; n < 300; n++) begin
            real v;
            v = 0.25 * $sin(pi2 * real'(n) / 32.0) * $sin(pi2 * real'(n) / 4.0 + pi2 / 8.0);
            send(to_q15(v), 1'b0, got);
            sc_out[n] = real'(got);
        end
        c_sc = corr_msg(1'b1);
        check("R11 suppressed-carrier correlation low", (c_sc < 0.2 && c_sc > -0.2), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule